// File: doc/BRIEF.md
# Flash Array Read Address Sequencer

This block produces the stream of byte addresses needed to read the main array of a serial flash device. A command decoder hands it an 8-bit read opcode and the 24-bit address that followed it. The block has two read modes. In array-streaming mode, reading runs across page boundaries and wraps from the top of the array back to page 0. In single-page mode, reading circles inside one page. After a command is accepted, the block counts the dummy serial clocks. It then announces each output byte with a one-cycle strobe.

Serial clock activity reaches the block as `sck_tick`, a one-cycle pulse in the system clock domain for each serial clock. A rising edge of chip select reaches it as `cs_rise`. The block fetches one byte ahead. It presents an address to the array together with `rd_req` a full byte slot before that byte is due. An array with a fixed latency shorter than one byte slot therefore always has its data ready in time. The block never writes anything, so the data buffers are left as they were.

Top module: `array_read_seq`

## Requirements
- R1: While reset is active and after it ends, `busy`, `rd_req` and `byte_start` are low until a read command is accepted.
- R2: A command is accepted only when `cmd_valid` is high, `busy` is low, `cs_rise` is low and the opcode is 68h or E8h (array-streaming) or 52h or D2h (single-page). Any other opcode, and any command that arrives while `busy` is high, is ignored: no request is issued and the running read continues unchanged.
- R3: Bits 8:0 of `cmd_addr` give the start byte and bits 20:9 give the start page. Bits 23:21 have no effect. In the cycle after the accepting clock edge, `busy` and `rd_req` are high and `rd_page`/`rd_byte` carry the start address.
- R4: The first `byte_start` is high in the cycle after the edge that captures the 32nd `sck_tick` counted after acceptance. A tick in the accepting cycle itself is not counted.
- R5: Each further `byte_start` follows after exactly 8 more ticks. The spacing is the same across page crossings and array wrap.
- R6: Every `byte_start` cycle also carries `rd_req` with the address of the following byte. `byte_start` marks the start of the byte requested by the previous `rd_req`. The address outputs hold their value between requests.
- R7: Inside a page the byte index rises by one. From byte 263, or from any start byte above 263, the next byte index is 0.
- R8: In array-streaming mode, leaving the last byte of a page moves to byte 0 of the next page, and page 4095 is followed by page 0.
- R9: In single-page mode the page index never changes during the read.
- R10: A `cs_rise` ends the read. In the next cycle `busy`, `rd_req` and `byte_start` are low, even if a tick or a command arrived in the same cycle.
- R11: An array model with a 3-cycle latency, fed by `rd_req` and the address, has delivered the data for each byte by the cycle in which that byte's `byte_start` appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_valid | input | 1 | One-cycle pulse presenting a decoded command |
| cmd_opcode | input | 8 | Command opcode |
| cmd_addr | input | 24 | Command address: reserved, page, byte |
| sck_tick | input | 1 | One pulse per serial clock cycle |
| cs_rise | input | 1 | Pulse on chip-select deassertion |
| rd_req | output | 1 | Array fetch request for the address on `rd_page`/`rd_byte` |
| rd_page | output | 12 | Page index of the address being fetched |
| rd_byte | output | 9 | Byte index of the address being fetched |
| byte_start | output | 1 | Data-valid strobe: the previously fetched byte starts shifting out |
| busy | output | 1 | A read is in progress |

## Verification
A bench reference model follows every clock edge and predicts what each output shows in the cycle after that edge. The start request is due one cycle after the accepting edge. The first strobe is due one cycle after the edge that holds the 32nd counted tick, and each later strobe comes 8 ticks after the one before. `busy` drops one cycle after the `cs_rise` edge. The bench samples 5 ns after each rising edge, while the inputs captured at that edge are still held. It compares the outputs with the model's prediction for that same edge, and checks that array data requested three cycles earlier or more is present at each strobe. Sweeps of start bytes around the page end, start pages at the top of the array, reserved address bits, foreign opcodes and early chip-select deassertion cover the wrap and ignore cases.

// File: rtl/array_read_seq_pkg.sv
package array_read_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DUMMY = 2'd1,
    PH_DATA  = 2'd2
  } phase_e;

  typedef enum logic {
    WRAP_IN_PAGE  = 1'b0,
    WRAP_ON_ARRAY = 1'b1
  } wrap_e;

  localparam logic [7:0] OPC_STREAM_A = 8'h68;
  localparam logic [7:0] OPC_STREAM_B = 8'hE8;
  localparam logic [7:0] OPC_PAGE_A   = 8'h52;
  localparam logic [7:0] OPC_PAGE_B   = 8'hD2;

endpackage

// File: rtl/ars_cmd_decode.sv
module ars_cmd_decode
  import array_read_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int PAGE_W = 12,
  parameter int BYTE_W = 9
) (
  input  logic [7:0]        opcode,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output wrap_e             wrap,
  output logic [PAGE_W-1:0] start_page,
  output logic [BYTE_W-1:0] start_byte
);

  localparam int RSV_W = ADDR_W - PAGE_W - BYTE_W;

  logic is_stream;
  logic is_page;
  logic unused_rsv;

  always_comb begin
    is_stream = (opcode == OPC_STREAM_A) || (opcode == OPC_STREAM_B);
    is_page   = (opcode == OPC_PAGE_A)   || (opcode == OPC_PAGE_B);
    hit       = is_stream || is_page;
    wrap      = is_stream ? WRAP_ON_ARRAY : WRAP_IN_PAGE;
  end

  assign start_byte = addr[BYTE_W-1:0];
  assign start_page = addr[BYTE_W +: PAGE_W];

  generate
    if (RSV_W > 0) begin : g_rsv
      assign unused_rsv = ^addr[ADDR_W-1 -: RSV_W];
    end else begin : g_no_rsv
      assign unused_rsv = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/ars_phase_ctrl.sv
module ars_phase_ctrl
  import array_read_seq_pkg::*;
#(
  parameter int DUMMY_TICKS = 32,
  parameter int BYTE_TICKS  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic stop,
  input  logic tick,
  output logic busy,
  output logic step
);

  localparam int MAX_T = (DUMMY_TICKS > BYTE_TICKS) ? DUMMY_TICKS : BYTE_TICKS;
  localparam int CNT_W = (MAX_T > 1) ? $clog2(MAX_T) : 1;
  localparam logic [CNT_W-1:0] DUMMY_LAST = CNT_W'(DUMMY_TICKS - 1);
  localparam logic [CNT_W-1:0] BYTE_LAST  = CNT_W'(BYTE_TICKS - 1);

  phase_e            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    step    = 1'b0;
    if (stop) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
      cnt_en  = 1'b1;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (load) begin
            phase_d = PH_DUMMY;
            cnt_d   = '0;
            cnt_en  = 1'b1;
          end
        end
        PH_DUMMY: begin
          if (tick) begin
            cnt_en = 1'b1;
            if (cnt_q == DUMMY_LAST) begin
              phase_d = PH_DATA;
              cnt_d   = '0;
              step    = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        PH_DATA: begin
          if (tick) begin
            cnt_en = 1'b1;
            if (cnt_q == BYTE_LAST) begin
              cnt_d = '0;
              step  = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign busy = (phase_q != PH_IDLE);

endmodule

// File: rtl/ars_addr_gen.sv
module ars_addr_gen
  import array_read_seq_pkg::*;
#(
  parameter int PAGE_W     = 12,
  parameter int BYTE_W     = 9,
  parameter int NUM_PAGES  = 4096,
  parameter int PAGE_BYTES = 264
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [PAGE_W-1:0] ld_page,
  input  logic [BYTE_W-1:0] ld_byte,
  input  wrap_e             ld_wrap,
  output logic [PAGE_W-1:0] page,
  output logic [BYTE_W-1:0] byte_idx,
  output wrap_e             wrap
);

  localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(PAGE_BYTES - 1);
  localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(NUM_PAGES - 1);

  logic [PAGE_W-1:0] page_q, page_d, page_inc;
  logic [BYTE_W-1:0] byte_q, byte_d;
  wrap_e             wrap_q, wrap_d;
  logic              at_end;
  logic              upd_en;

  generate
    if (NUM_PAGES == (1 << PAGE_W)) begin : g_pow2_pages
      assign page_inc = page_q + 1'b1;
    end else begin : g_odd_pages
      assign page_inc = (page_q >= LAST_PAGE) ? '0 : page_q + 1'b1;
    end
  endgenerate

  always_comb begin
    at_end = (byte_q >= LAST_BYTE);
    page_d = page_q;
    byte_d = byte_q;
    wrap_d = wrap_q;
    upd_en = load || step;
    if (load) begin
      page_d = ld_page;
      byte_d = ld_byte;
      wrap_d = ld_wrap;
    end else if (step) begin
      if (at_end) begin
        byte_d = '0;
        if (wrap_q == WRAP_ON_ARRAY) begin
          page_d = page_inc;
        end
      end else begin
        byte_d = byte_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      byte_q <= '0;
      wrap_q <= WRAP_IN_PAGE;
    end else if (upd_en) begin
      page_q <= page_d;
      byte_q <= byte_d;
      wrap_q <= wrap_d;
    end
  end

  assign page     = page_q;
  assign byte_idx = byte_q;
  assign wrap     = wrap_q;

endmodule

// File: rtl/array_read_seq.sv
module array_read_seq
  import array_read_seq_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int PAGE_W      = 12,
  parameter int BYTE_W      = 9,
  parameter int NUM_PAGES   = 4096,
  parameter int PAGE_BYTES  = 264,
  parameter int DUMMY_TICKS = 32,
  parameter int BYTE_TICKS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_opcode,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              sck_tick,
  input  logic              cs_rise,
  output logic              rd_req,
  output logic [PAGE_W-1:0] rd_page,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              byte_start,
  output logic              busy
);

  logic [1:0]        rst_sync_q;
  logic              srst_n;
  logic              dec_hit;
  wrap_e             dec_wrap;
  wrap_e             cur_wrap;
  logic [PAGE_W-1:0] dec_page;
  logic [BYTE_W-1:0] dec_byte;
  logic              load;
  logic              step;
  logic              busy_int;
  logic              req_d, strobe_d;
  logic              req_q, strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign srst_n = rst_sync_q[1];

  ars_cmd_decode #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W),
    .BYTE_W (BYTE_W)
  ) u_decode (
    .opcode     (cmd_opcode),
    .addr       (cmd_addr),
    .hit        (dec_hit),
    .wrap       (dec_wrap),
    .start_page (dec_page),
    .start_byte (dec_byte)
  );

  assign load = cmd_valid && dec_hit && !busy_int && !cs_rise;

  ars_phase_ctrl #(
    .DUMMY_TICKS (DUMMY_TICKS),
    .BYTE_TICKS  (BYTE_TICKS)
  ) u_phase (
    .clk   (clk),
    .rst_n (srst_n),
    .load  (load),
    .stop  (cs_rise),
    .tick  (sck_tick),
    .busy  (busy_int),
    .step  (step)
  );

  ars_addr_gen #(
    .PAGE_W     (PAGE_W),
    .BYTE_W     (BYTE_W),
    .NUM_PAGES  (NUM_PAGES),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_addr (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (load),
    .step     (step),
    .ld_page  (dec_page),
    .ld_byte  (dec_byte),
    .ld_wrap  (dec_wrap),
    .page     (rd_page),
    .byte_idx (rd_byte),
    .wrap     (cur_wrap)
  );

  always_comb begin
    req_d    = load || step;
    strobe_d = step;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      req_q    <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      req_q    <= req_d;
      strobe_q <= strobe_d;
    end
  end

  assign rd_req     = req_q;
  assign byte_start = strobe_q;
  assign busy       = busy_int;

endmodule

// File: rtl/array_read_seq_chk.sv
module array_read_seq_chk
  import array_read_seq_pkg::*;
#(
  parameter int PAGE_W     = 12,
  parameter int BYTE_W     = 9,
  parameter int NUM_PAGES  = 4096,
  parameter int PAGE_BYTES = 264
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_rise,
  input logic              busy,
  input logic              rd_req,
  input logic              byte_start,
  input logic [PAGE_W-1:0] rd_page,
  input logic [BYTE_W-1:0] rd_byte,
  input wrap_e             cur_wrap
);

  localparam logic [BYTE_W-1:0] C_LAST_BYTE = BYTE_W'(PAGE_BYTES - 1);
  localparam logic [PAGE_W-1:0] C_LAST_PAGE = PAGE_W'(NUM_PAGES - 1);

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!byte_start && !rd_req)); // R1

  AST_STOP_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_rise) |-> (!busy && !rd_req && !byte_start)); // R10

  AST_STROBE_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    byte_start |-> rd_req); // R6

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !rd_req) |-> ($stable(rd_byte) && $stable(rd_page))); // R6

  AST_BYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && $past(busy) && ($past(rd_byte) < C_LAST_BYTE))
      |-> (rd_byte == BYTE_W'($past(rd_byte) + 1'b1))); // R7

  AST_BYTE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && $past(busy) && ($past(rd_byte) >= C_LAST_BYTE)) |-> (rd_byte == '0)); // R7

  AST_PAGE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && $past(busy) && (cur_wrap == WRAP_ON_ARRAY) && ($past(rd_byte) >= C_LAST_BYTE))
      |-> (rd_page == (($past(rd_page) == C_LAST_PAGE) ? '0 : PAGE_W'($past(rd_page) + 1'b1)))); // R8

  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (cur_wrap == WRAP_IN_PAGE)) |-> $stable(rd_page)); // R9

endmodule

bind array_read_seq array_read_seq_chk #(
  .PAGE_W     (PAGE_W),
  .BYTE_W     (BYTE_W),
  .NUM_PAGES  (NUM_PAGES),
  .PAGE_BYTES (PAGE_BYTES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_rise    (cs_rise),
  .busy       (busy),
  .rd_req     (rd_req),
  .byte_start (byte_start),
  .rd_page    (rd_page),
  .rd_byte    (rd_byte),
  .cur_wrap   (cur_wrap)
);

// File: tb/array_read_seq_tb_top.sv
module array_read_seq_tb_top;

  localparam int NPAGES = 4096;
  localparam int NBYTES = 264;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_opcode = 8'h00;
  logic [23:0] cmd_addr = 24'h0;
  logic        sck_tick = 1'b0;
  logic        tick_en = 1'b0;
  logic        cs_rise = 1'b0;
  logic        rd_req;
  logic [11:0] rd_page;
  logic [8:0]  rd_byte;
  logic        byte_start;
  logic        busy;

  int n_checks = 0;
  int n_errors = 0;
  string cur_tag = "R1";
  bit finished = 1'b0;

  // reference model state
  bit       m_busy = 1'b0;
  bit       m_stream = 1'b0;
  int       m_ticks = 0;
  int       m_strobes = 0;
  int       m_next_pg = 0;
  int       m_next_by = 0;
  int       m_cur_pg = 0;
  int       m_cur_by = 0;

  // array model with a fixed 3-cycle latency
  logic [20:0] mem_a [3];
  logic        mem_v [3];
  logic [20:0] mem_hold = '0;

  always #10 clk = ~clk;

  array_read_seq dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_opcode (cmd_opcode),
    .cmd_addr   (cmd_addr),
    .sck_tick   (sck_tick),
    .cs_rise    (cs_rise),
    .rd_req     (rd_req),
    .rd_page    (rd_page),
    .rd_byte    (rd_byte),
    .byte_start (byte_start),
    .busy       (busy)
  );

  always @(negedge clk) sck_tick <= tick_en ? ~sck_tick : 1'b0;

  always @(posedge clk) begin
    mem_v[0] <= rd_req;
    mem_a[0] <= {rd_page, rd_byte};
    mem_v[1] <= mem_v[0];
    mem_a[1] <= mem_a[0];
    mem_v[2] <= mem_v[1];
    mem_a[2] <= mem_a[1];
    if (mem_v[2] === 1'b1) mem_hold <= mem_a[2];
  end

  function automatic bit op_ok(input logic [7:0] op);
    return (op == 8'h68) || (op == 8'hE8) || (op == 8'h52) || (op == 8'hD2);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // per-edge prediction, sampled 5 ns after the edge
  always @(posedge clk) begin
    bit    exp_req;
    bit    exp_stb;
    string tag;
    #5;
    exp_req = 1'b0;
    exp_stb = 1'b0;
    tag = cur_tag;
    if (!rst_n) begin
      m_busy = 1'b0;
    end else begin
      if (cs_rise) begin
        m_busy = 1'b0;
        tag = "R10";
      end else if (m_busy) begin
        if (sck_tick) begin
          m_ticks++;
          if (m_ticks >= 32 && ((m_ticks - 32) % 8) == 0) begin
            exp_stb = 1'b1;
            exp_req = 1'b1;
            m_strobes++;
            m_cur_pg = m_next_pg;
            m_cur_by = m_next_by;
            if (m_next_by >= NBYTES - 1) begin
              m_next_by = 0;
              if (m_stream) m_next_pg = (m_next_pg + 1) % NPAGES;
            end else begin
              m_next_by++;
            end
            tag = (m_ticks == 32) ? "R4" : "R5";
          end
        end
      end else if (cmd_valid && op_ok(cmd_opcode)) begin
        m_busy    = 1'b1;
        m_ticks   = 0;
        m_stream  = (cmd_opcode == 8'h68) || (cmd_opcode == 8'hE8);
        m_next_pg = int'(cmd_addr[20:9]);
        m_next_by = int'(cmd_addr[8:0]);
        exp_req   = 1'b1;
        tag = "R3";
      end
      if (exp_req || exp_stb || rd_req || byte_start || (busy !== m_busy)) begin
        n_checks++;
        if (rd_req !== exp_req || byte_start !== exp_stb || busy !== m_busy) begin
          n_errors++;
          $display("FAIL %s: req/strobe/busy actual %b%b%b expected %b%b%b (tick %0d)",
                   tag, rd_req, byte_start, busy, exp_req, exp_stb, m_busy, m_ticks);
        end else if (exp_req && (int'(rd_page) != m_next_pg || int'(rd_byte) != m_next_by)) begin
          n_errors++;
          $display("FAIL %s (R6/R7/R8/R9): address actual %0d:%0d expected %0d:%0d",
                   tag, rd_page, rd_byte, m_next_pg, m_next_by);
        end else if (exp_stb && (mem_hold !== {m_cur_pg[11:0], m_cur_by[8:0]})) begin
          n_errors++;
          $display("FAIL R11: array data actual %0d:%0d expected %0d:%0d",
                   mem_hold[20:9], mem_hold[8:0], m_cur_pg, m_cur_by);
        end
      end
    end
  end

  task automatic send_cmd(input logic [7:0] op, input logic [23:0] addr);
    @(negedge clk);
    cmd_valid  = 1'b1;
    cmd_opcode = op;
    cmd_addr   = addr;
    @(negedge clk);
    cmd_valid  = 1'b0;
  endtask

  task automatic end_read();
    @(negedge clk);
    cs_rise = 1'b1;
    @(negedge clk);
    cs_rise = 1'b0;
  endtask

  task automatic run_read(input logic [7:0] op, input logic [2:0] rsv, input int pg,
                          input int by, input int nbytes);
    int target;
    send_cmd(op, {rsv, pg[11:0], by[8:0]});
    target = m_strobes + nbytes;
    while (m_strobes < target) @(negedge clk);
    end_read();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops [4];
    logic [7:0] bad [5];
    int starts [8];
    ops[0] = 8'h68; ops[1] = 8'hE8; ops[2] = 8'h52; ops[3] = 8'hD2;
    bad[0] = 8'h53; bad[1] = 8'h69; bad[2] = 8'h00; bad[3] = 8'hD7; bad[4] = 8'h84;
    starts[0] = 258; starts[1] = 259; starts[2] = 260; starts[3] = 261;
    starts[4] = 262; starts[5] = 263; starts[6] = 300; starts[7] = 511;

    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check("R1 busy in reset", int'(busy), 0);
    check("R1 rd_req in reset", int'(rd_req), 0);
    rst_n = 1'b1;
    tick_en = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 byte_start after reset", int'(byte_start), 0);

    // R2: foreign opcodes ignored
    cur_tag = "R2";
    for (int i = 0; i < 5; i++) begin
      send_cmd(bad[i], 24'h000A05);
      repeat (4) @(negedge clk);
      check("R2 foreign opcode leaves busy low", int'(busy), 0);
    end

    // R3: reserved bits ignored
    cur_tag = "R3";
    run_read(8'h68, 3'b101, 5, 3, 4);
    run_read(8'h52, 3'b111, 4094, 100, 3);

    // R7 R8 R9: start-byte sweep around the page end, top of array and mid array
    for (int o = 0; o < 4; o++) begin
      for (int s = 0; s < 8; s++) begin
        cur_tag = (o < 2) ? "R8" : "R9";
        run_read(ops[o], 3'b000, (s % 2 == 0) ? 4095 : 17, starts[s], 10);
      end
    end

    // R5 R8: full page crossing in streaming mode, spacing unchanged
    cur_tag = "R8";
    run_read(8'hE8, 3'b000, 2, 0, 270);
    // R9: whole page plus wrap in single-page mode
    cur_tag = "R9";
    run_read(8'hD2, 3'b010, 300, 0, 270);

    // R2: a second command during a read is ignored
    cur_tag = "R2";
    send_cmd(8'h68, {3'b000, 12'd40, 9'd7});
    repeat (20) @(negedge clk);
    send_cmd(8'h52, {3'b000, 12'd99, 9'd1});
    while (m_strobes < 0) @(negedge clk);
    repeat (120) @(negedge clk);
    check("R2 busy kept by first read", int'(busy), 1);
    end_read();
    repeat (3) @(negedge clk);

    // R10: chip-select rise during the dummy phase
    cur_tag = "R10";
    send_cmd(8'h68, {3'b000, 12'd1, 9'd0});
    repeat (21) @(negedge clk);
    end_read();
    check("R10 busy after stop", int'(busy), 0);
    repeat (80) @(negedge clk);
    check("R10 no strobe after stop", int'(byte_start), 0);

    // R10: stop in the data phase, then immediate restart
    send_cmd(8'hE8, {3'b000, 12'd4095, 9'd262});
    repeat (90) @(negedge clk);
    end_read();
    cur_tag = "R4";
    run_read(8'h52, 3'b000, 8, 261, 5);

    // R10: stop and command in the same cycle: command ignored
    cur_tag = "R10";
    @(negedge clk);
    cmd_valid = 1'b1; cmd_opcode = 8'h68; cmd_addr = 24'h000200; cs_rise = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cs_rise = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 command with stop ignored", int'(busy), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule